// File: doc/BRIEF.md
# Video Mode Detector and Window Capture

This block sits between a raw video input and a display frame buffer. It watches the vertical and horizontal sync lines and counts how many lines fall between two frame syncs. From that count it decides whether the source runs at quarter-VGA line rate or full VGA line rate. A new decision is taken at a frame sync only after a set evaluation interval has passed since the last one, so the block follows a source that changes format while running. A count that fits neither band leaves the current decision as it is.

Using that decision, the block turns the pixel clock edges into frame buffer writes. Each write carries a row address, a column address and the 4-bit pixel value. The captured window is `V_ROWS` by `H_PIX`, which is 240 by 320 by default. The first captured row follows a fixed number of line syncs, and that number depends on the detected rate. A VGA source therefore yields only its upper-left quadrant.

Two select pins pick how each row's first pixel is found. It can be the first pixel clock after the line sync, a fixed number of pixel clocks after it, or the first pixel marked by the data-enable line. When the source stops, no writes occur and the buffer keeps the last frame. All inputs are synchronised to the system clock, and pixels are taken on falling pixel-clock edges.

Top module: `vid_win_capture`

## Requirements
- R1: While reset is asserted and after its release, `mode` reads 2'b00 (no format) and `wr_en` is low until a format has been detected.
- R2: A frame of between `VGA_LINES_MIN` and `VGA_LINES_MAX` line-sync rising edges (default 515 to 560), counted between two frame-sync rising edges, sets `mode` to 2'b10 (VGA rate) at the closing frame sync.
- R3: A frame of between `QV_LINES_MIN` and `QV_LINES_MAX` line-sync rising edges (default 251 to 280) sets `mode` to 2'b01 (quarter-VGA rate) at the closing frame sync.
- R4: A frame whose line count lies in neither band leaves `mode` unchanged.
- R5: A decision is taken only at a frame-sync rising edge. That edge must come at least `EVAL_CYCLES` system clocks after the previous decision (default 6,250,000, which is 25 ms at 250 MHz), and the first complete frame after reset always qualifies. A qualifying later frame of a different class switches `mode` at once.
- R6: Row r of the window is the line that follows line-sync rising edge number `VST_VGA + r` (VGA, default 34) or `VST_QV + r` (quarter VGA, default 7) after the frame sync, for r from 0 to `V_ROWS-1`. No other line is written.
- R7: With `msel[1]` = 1, column c is the pixel taken at the (c+1)-th falling pixel-clock edge after the line sync falls.
- R8: With `msel` = 2'b01, the first `FIX_HSTART` falling pixel-clock edges after the line sync falls are skipped, and column c is the edge after them.
- R9: With `msel` = 2'b00, only pixels with data-enable high are counted, and column c is the (c+1)-th of them in the line.
- R10: At most `H_PIX` columns are written per row, so the columns beyond them are dropped. Nothing is written while `mode` is 2'b00.
- R11: When the pixel clock and both syncs stop, no writes occur and `mode` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vclk | input | 1 | Pixel clock; pixels are taken on its falling edge |
| hs | input | 1 | Line sync |
| vs | input | 1 | Frame sync |
| de | input | 1 | Data-enable marking valid pixels |
| pix | input | 4 | Pixel data |
| msel | input | 2 | Horizontal start select: 1x after sync, 01 fixed offset, 00 data-enable |
| mode | output | 2 | Detected format: 00 none, 01 quarter VGA, 10 VGA |
| wr_en | output | 1 | Frame buffer write strobe |
| wr_row | output | clog2(V_ROWS) | Row address of the write |
| wr_col | output | clog2(H_PIX) | Column address of the write |
| wr_data | output | 4 | Pixel value of the write |

## Verification
A wrong line count shows at the next qualifying frame sync as a wrong `mode`. It also shows within the first captured line as row addresses shifted against the line whose data they carry. A corrupted pixel counter gives a mismatch between `wr_data` and the value expected for (`wr_row`, `wr_col`) on the first write of the next line. It can also change how many writes a frame produces. An evaluation timer that runs too fast or too slow shows up only when frames follow each other faster than the interval, and then as a `mode` that switches early or never.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_QV   = 2'b01,
    MODE_VGA  = 2'b10
  } vmode_e;
endpackage

// File: rtl/vwc_sync.sv
module vwc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/vwc_mode_det.sv
module vwc_mode_det
  import vwc_pkg::*;
#(
  parameter int LCNT_W        = 10,
  parameter int VGA_LINES_MIN = 515,
  parameter int VGA_LINES_MAX = 560,
  parameter int QV_LINES_MIN  = 251,
  parameter int QV_LINES_MAX  = 280,
  parameter int EVAL_CYCLES   = 6250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise,
  input  logic              vs_rise,
  output logic [LCNT_W-1:0] line_cnt,
  output vmode_e            mode
);
  localparam int TW = $clog2(EVAL_CYCLES + 1);

  logic [LCNT_W-1:0] lcnt_q, lcnt_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              pend_q, pend_d;
  logic              ref_q, ref_d;
  vmode_e            mode_q, mode_d;
  logic              in_vga, in_qv;

  assign in_vga = (lcnt_q >= LCNT_W'(VGA_LINES_MIN)) && (lcnt_q <= LCNT_W'(VGA_LINES_MAX));
  assign in_qv  = (lcnt_q >= LCNT_W'(QV_LINES_MIN))  && (lcnt_q <= LCNT_W'(QV_LINES_MAX));

  always_comb begin
    lcnt_d = lcnt_q;
    tmr_d  = tmr_q;
    pend_d = pend_q;
    ref_d  = ref_q;
    mode_d = mode_q;
    if (vs_rise) begin
      lcnt_d = '0;
    end else if (hs_rise && (lcnt_q != '1)) begin
      lcnt_d = lcnt_q + 1'b1;
    end
    if (!pend_q) begin
      if (tmr_q == TW'(EVAL_CYCLES - 1)) pend_d = 1'b1;
      else                               tmr_d  = tmr_q + 1'b1;
    end
    if (vs_rise) begin
      ref_d = 1'b1;
      if (ref_q && pend_q) begin
        pend_d = 1'b0;
        tmr_d  = '0;
        if (in_vga)     mode_d = MODE_VGA;
        else if (in_qv) mode_d = MODE_QV;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt_q <= '0;
      tmr_q  <= '0;
      pend_q <= 1'b1;
      ref_q  <= 1'b0;
      mode_q <= MODE_NONE;
    end else begin
      lcnt_q <= lcnt_d;
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
      ref_q  <= ref_d;
      mode_q <= mode_d;
    end
  end

  assign line_cnt = lcnt_q;
  assign mode     = mode_q;

  // R5: a decision only follows a qualifying frame-sync edge
  assert_mode_on_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(vs_rise && pend_q && ref_q));

  // R4: an out-of-band count never changes the decision
  assert_keep_out_of_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && !in_vga && !in_qv) |=> $stable(mode_q));

  // R1: the code 2'b11 is never produced
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11);
endmodule

// File: rtl/vwc_capture.sv
module vwc_capture
  import vwc_pkg::*;
#(
  parameter int H_PIX      = 320,
  parameter int V_ROWS     = 240,
  parameter int VST_VGA    = 34,
  parameter int VST_QV     = 7,
  parameter int FIX_HSTART = 16,
  parameter int LCNT_W     = 10,
  localparam int CW  = $clog2(H_PIX),
  localparam int RW  = $clog2(V_ROWS),
  localparam int PCW = $clog2(FIX_HSTART + H_PIX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_fall,
  input  logic              vclk_fall,
  input  logic              de,
  input  logic [3:0]        pix,
  input  logic [1:0]        msel,
  input  vmode_e            mode,
  input  logic [LCNT_W-1:0] line_cnt,
  output logic              wr_en,
  output logic [RW-1:0]     wr_row,
  output logic [CW-1:0]     wr_col,
  output logic [3:0]        wr_data
);
  logic [PCW-1:0]    pcnt_q, pcnt_d;
  logic [PCW-1:0]    ofs;
  logic [LCNT_W-1:0] vstart, vend;
  logic              counts, row_ok, take;
  logic              wen_q;
  logic [RW-1:0]     row_q;
  logic [CW-1:0]     col_q;
  logic [3:0]        dat_q;

  always_comb begin
    vstart = (mode == MODE_VGA) ? LCNT_W'(VST_VGA) : LCNT_W'(VST_QV);
    vend   = vstart + LCNT_W'(V_ROWS);
    ofs    = (msel == 2'b01) ? PCW'(FIX_HSTART) : '0;
    counts = (msel == 2'b00) ? de : 1'b1;
    row_ok = (mode != MODE_NONE) && (line_cnt >= vstart) && (line_cnt < vend);
    take   = vclk_fall && counts && row_ok &&
             (pcnt_q >= ofs) && (pcnt_q < ofs + PCW'(H_PIX));
    pcnt_d = pcnt_q;
    if (hs_fall) begin
      pcnt_d = '0;
    end else if (vclk_fall && counts && (pcnt_q != '1)) begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      wen_q  <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      dat_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      wen_q  <= take;
      if (take) begin
        row_q <= RW'(line_cnt - vstart);
        col_q <= CW'(pcnt_q - ofs);
        dat_q <= pix;
      end
    end
  end

  assign wr_en   = wen_q;
  assign wr_row  = row_q;
  assign wr_col  = col_q;
  assign wr_data = dat_q;

  // R10: no write before a format is known
  assert_no_write_unknown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wen_q |-> $past(mode != MODE_NONE));

  // R6, R10: write addresses stay inside the window
  assert_addr_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wen_q |-> ((int'(row_q) < V_ROWS) && (int'(col_q) < H_PIX)));

  // R9: in data-enable mode a write needs enable on the sampled edge
  assert_de_gates_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_q && $past(msel == 2'b00)) |-> $past(de && vclk_fall));
endmodule

// File: rtl/vid_win_capture.sv
module vid_win_capture
  import vwc_pkg::*;
#(
  parameter int H_PIX         = 320,
  parameter int V_ROWS        = 240,
  parameter int VST_VGA       = 34,
  parameter int VST_QV        = 7,
  parameter int FIX_HSTART    = 16,
  parameter int VGA_LINES_MIN = 515,
  parameter int VGA_LINES_MAX = 560,
  parameter int QV_LINES_MIN  = 251,
  parameter int QV_LINES_MAX  = 280,
  parameter int EVAL_CYCLES   = 6250000,
  parameter int LCNT_W        = 10,
  localparam int CW = $clog2(H_PIX),
  localparam int RW = $clog2(V_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vclk,
  input  logic          hs,
  input  logic          vs,
  input  logic          de,
  input  logic [3:0]    pix,
  input  logic [1:0]    msel,
  output logic [1:0]    mode,
  output logic          wr_en,
  output logic [RW-1:0] wr_row,
  output logic [CW-1:0] wr_col,
  output logic [3:0]    wr_data
);
  logic [7:0]        s_bus;
  logic              vclk_s, hs_s, vs_s, de_s;
  logic [3:0]        pix_s;
  logic              vclk_p, hs_p, vs_p;
  logic              vclk_fall, hs_rise, hs_fall, vs_rise;
  logic [LCNT_W-1:0] line_cnt;
  vmode_e            mode_w;

  vwc_sync #(.W(8)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({vclk, hs, vs, de, pix}),
    .q(s_bus)
  );
  assign {vclk_s, hs_s, vs_s, de_s, pix_s} = s_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vclk_p <= 1'b0;
      hs_p   <= 1'b0;
      vs_p   <= 1'b0;
    end else begin
      vclk_p <= vclk_s;
      hs_p   <= hs_s;
      vs_p   <= vs_s;
    end
  end

  assign vclk_fall = vclk_p & ~vclk_s;
  assign hs_rise   = ~hs_p & hs_s;
  assign hs_fall   = hs_p & ~hs_s;
  assign vs_rise   = ~vs_p & vs_s;

  vwc_mode_det #(
    .LCNT_W(LCNT_W), .VGA_LINES_MIN(VGA_LINES_MIN), .VGA_LINES_MAX(VGA_LINES_MAX),
    .QV_LINES_MIN(QV_LINES_MIN), .QV_LINES_MAX(QV_LINES_MAX), .EVAL_CYCLES(EVAL_CYCLES)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .line_cnt(line_cnt), .mode(mode_w)
  );

  vwc_capture #(
    .H_PIX(H_PIX), .V_ROWS(V_ROWS), .VST_VGA(VST_VGA), .VST_QV(VST_QV),
    .FIX_HSTART(FIX_HSTART), .LCNT_W(LCNT_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .hs_fall(hs_fall), .vclk_fall(vclk_fall),
    .de(de_s), .pix(pix_s), .msel(msel), .mode(mode_w), .line_cnt(line_cnt),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
  );

  assign mode = mode_w;
endmodule

// File: tb/vid_win_capture_bench.sv
module vid_win_capture_bench;
  localparam int HP = 8;
  localparam int VR = 4;
  localparam int VSTV = 6;
  localparam int VSTQ = 3;
  localparam int FIXS = 2;
  localparam int DEOFS = 3;
  localparam int NPIX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vclk = 1'b1, hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [3:0] pix = '0;
  logic [1:0] msel = 2'b10;
  logic [1:0] mode;
  logic wr_en;
  logic [1:0] wr_row;
  logic [2:0] wr_col;
  logic [3:0] wr_data;

  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0, nwr = 0;
  int vst = 0, ofs = 0;
  bit cnt_on = 0, data_on = 0;
  string tag = "R7";
  logic [1:0] held;

  always #2 clk = ~clk;

  vid_win_capture #(
    .H_PIX(HP), .V_ROWS(VR), .VST_VGA(VSTV), .VST_QV(VSTQ), .FIX_HSTART(FIXS),
    .VGA_LINES_MIN(40), .VGA_LINES_MAX(48), .QV_LINES_MIN(20), .QV_LINES_MAX(26),
    .EVAL_CYCLES(300), .LCNT_W(8)
  ) u_vid_win_capture (
    .clk(clk), .rst_n(rst_n), .vclk(vclk), .hs(hs), .vs(vs), .de(de), .pix(pix),
    .msel(msel), .mode(mode), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data)
  );

  // vector: msel[11:10], lines[9:2], expected mode[1:0]
  localparam logic [11:0] VEC [7] = '{
    {2'b10, 8'd24, 2'b01},
    {2'b10, 8'd44, 2'b10},
    {2'b01, 8'd44, 2'b10},
    {2'b00, 8'd22, 2'b01},
    {2'b00, 8'd46, 2'b10},
    {2'b01, 8'd20, 2'b01},
    {2'b11, 8'd48, 2'b10}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cnt_on && wr_en) begin
      nwr++;
      if (data_on) begin
        automatic logic [3:0] e = 4'(((int'(wr_row) + vst) * 3) + int'(wr_col) + ofs);
        m_chk++;
        if (wr_data !== e) begin
          m_fail++;
          $display("FAIL %s/R6 row=%0d col=%0d actual=%0d expected=%0d",
                   tag, wr_row, wr_col, wr_data, e);
        end
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line(input int k, input int npix, input int hsw);
    hs = 1'b1; wait_n(hsw); hs = 1'b0;
    for (int p = 0; p < npix; p++) begin
      pix = 4'(k * 3 + p);
      de = (p >= DEOFS) && (p < DEOFS + HP + 4);
      vclk = 1'b1; wait_n(2);
      vclk = 1'b0; wait_n(2);
    end
    vclk = 1'b1; de = 1'b0;
    if (npix == 0) wait_n(hsw);
  endtask

  task automatic vs_pulse();
    vs = 1'b1; wait_n(4); vs = 1'b0; wait_n(2);
  endtask

  task automatic frame(input int lines, input int npix);
    vs_pulse();
    for (int k = 1; k <= lines; k++) line(k, npix, 6);
  endtask

  initial begin
    wait_n(5);
    chk(mode == 2'b00, "R1 mode in reset", mode, 0);
    chk(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
    rst_n = 1'b1;
    wait_n(3);
    chk(mode == 2'b00, "R1 mode after reset", mode, 0);

    // first frame: no format yet, nothing written
    msel = 2'b10; nwr = 0; cnt_on = 1;
    frame(24, NPIX);
    cnt_on = 0;
    chk(nwr == 0, "R10 no write while format unknown", nwr, 0);

    for (int i = 0; i < 7; i++) begin
      automatic logic [1:0] ms = VEC[i][11:10];
      automatic int nl = int'(VEC[i][9:2]);
      automatic logic [1:0] em = VEC[i][1:0];
      msel = ms;
      if (i > 0) frame(nl, NPIX);
      vst = (em == 2'b10) ? VSTV : VSTQ;
      ofs = ms[1] ? 0 : (ms == 2'b01) ? FIXS : DEOFS;
      tag = ms[1] ? "R7" : (ms == 2'b01) ? "R8" : "R9";
      nwr = 0; cnt_on = 1; data_on = 1;
      frame(nl, NPIX);
      chk(mode == em, (em == 2'b10) ? "R2 VGA band" : "R3 quarter-VGA band", mode, em);
      frame(nl, NPIX);
      cnt_on = 0; data_on = 0;
      chk(nwr == 2 * HP * VR, "R6/R10 writes per two frames", nwr, 2 * HP * VR);
    end

    // R4: out-of-band frames keep the decision
    frame(33, NPIX);
    frame(33, NPIX);
    vs_pulse(); wait_n(10);
    chk(mode == 2'b10, "R4 out-of-band keeps mode", mode, 2);

    // R5: a decision before the interval is skipped, a later one switches
    for (int k = 1; k <= 22; k++) line(k, 0, 3);
    vs_pulse(); wait_n(10);
    chk(mode == 2'b10, "R5 early frame sync ignored", mode, 2);
    for (int k = 1; k <= 22; k++) line(k, 0, 3);
    wait_n(400);
    vs_pulse(); wait_n(10);
    chk(mode == 2'b01, "R5 switch after interval", mode, 1);

    // R11: halted input
    held = mode; nwr = 0; cnt_on = 1;
    wait_n(2000);
    cnt_on = 0;
    chk(nwr == 0, "R11 no writes on halt", nwr, 0);
    chk(mode == held, "R11 mode held on halt", mode, held);

    n_chk += m_chk; n_fail += m_fail;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk += m_chk + 1; n_fail += m_fail + 1;
    $display("FAIL watchdog R11 actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule